// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with APB Register Access

This block is a single-channel down-counter that software controls through four word-wide registers on an APB3 slave with no wait states. Software writes a start value. The value goes into the counter at once. Software then picks a clock division ratio and a mode, and sets the run bit. While the timer runs, the counter steps down by one on every prescaled tick. When it steps from one to zero it raises a level interrupt. The interrupt stays high until software writes to the clear register.

There are two modes. In periodic mode the counter refills from the stored start value on the tick after it reaches zero. In free-running mode it wraps to all ones on that tick. The ratio code is not ordered by size, so each code has its own divider output. Writing the start value also restarts the divider, which gives software a clean full first interval.

Top module: `apb_dtimer`

## Requirements
- R1: After reset, reads at the start-value (0x0), count (0x4) and control (0x8) registers all return 0, and `irq` is low.
- R2: Offset 0x0 holds a 16-bit start value and reads back only in bits [15:0]. Writing it copies the value into the counter at once, so the count register at 0x4 returns that value straight away.
- R3: The count register at 0x4 is read-only. A write there changes neither the count nor the start value.
- R4: The control register at 0x8 has these fields: bits [4:2] ratio code, bit 6 mode (1 = periodic), bit 7 run, bit 8 interrupt status. Bit 8 ignores writes. Bits 0, 1, 5 and 9 and above always read 0.
- R5: Ratio codes 0 to 7 divide the clock by 1, 16, 256, 2, 8, 32, 128 and 1024. After the run bit is set, with start value N and the divider just restarted, the interrupt rises exactly N×ratio clock edges after the enabling write.
- R6: The interrupt is set when a tick moves the counter from 1 to 0. The `irq` output always equals control bit 8.
- R7: On the tick after the counter reaches 0, periodic mode reloads the start value and free-running mode wraps to 0xFFFF. In periodic mode, interrupts therefore come every (N+1)×ratio edges.
- R8: A write of any data to offset 0xC clears the interrupt. Offset 0xC reads as 0.
- R9: If a 1→0 tick and a clear write fall on the same edge, the interrupt ends up set.
- R10: While the run bit is 0, the count and the divider phase are frozen. When the run bit is set again, counting resumes from the same divider phase.
- R11: A start-value write restarts the divider. The first tick after it comes a full ratio of edges later.
- R12: `pready` is always high and `pslverr` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W (4) | Byte address; bits [3:2] pick the register |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, combinational from the selected register |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
Register writes act on the edge that closes the access phase, so they count as starting from that edge. A read returns the state left by the edge that ends its setup phase. The bench keeps a free-running edge counter. It places every read so that the state being read is a known number of edges after the triggering write. The interrupt is timed by polling `irq` after every edge and comparing the elapsed edge count with N×ratio exactly. The same-edge set/clear case is built by lining up the access edge of a clear write with the known zero-crossing edge, and by checking a neighbouring case one edge earlier.

// File: rtl/dtim_pkg.sv
package dtim_pkg;

   localparam int PSC_W  = 10;
   localparam int CODE_W = 3;
   localparam int NCODES = 1 << CODE_W;

   localparam int CTL_PSC_LSB = 2;
   localparam int CTL_PER_BIT = 6;
   localparam int CTL_RUN_BIT = 7;
   localparam int CTL_STS_BIT = 8;

   typedef enum logic [1:0] {
      SEL_START = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_ACK   = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic              run;
      logic              periodic;
      logic [CODE_W-1:0] code;
   } ctl_t;

   // log2 of the division ratio for each code
   function automatic int unsigned code_shift(input int unsigned code);
      case (code)
         0:       return 0;
         1:       return 4;
         2:       return 8;
         3:       return 1;
         4:       return 3;
         5:       return 5;
         6:       return 7;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/dtim_prescaler.sv
module dtim_prescaler
   import dtim_pkg::*;
#(
   parameter int PW = PSC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);

   logic [PW-1:0]     phase;
   logic [NCODES-1:0] hit;

   for (genvar c = 0; c < NCODES; c++) begin : g_code
      localparam int unsigned SH = code_shift(c);
      if (SH > PW) begin : g_bad
         $error("prescaler width too small for ratio code");
      end
      if (SH == 0) begin : g_div1
         assign hit[c] = 1'b1;
      end else begin : g_divn
         assign hit[c] = &phase[SH-1:0];
      end
   end

   assign tick = run & hit[code];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (restart)
         phase <= '0;
      else if (run)
         phase <= phase + 1'b1;
   end

   AST_PSC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(phase)); // R10
   AST_PSC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase == '0)); // R11

endmodule

// File: rtl/dtim_counter.sv
module dtim_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             periodic,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] start_val,
   input  logic [CNT_W-1:0] load_data,
   input  logic             ack_wr,
   output logic [CNT_W-1:0] count,
   output logic             flag
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic step;
   logic at_zero;
   logic hits_zero;

   assign step      = tick & ~load_wr;
   assign at_zero   = (count == '0);
   assign hits_zero = step & (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (load_wr)
         count <= load_data;
      else if (step) begin
         if (at_zero)
            count <= periodic ? start_val : '1;
         else
            count <= count - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (hits_zero)
         flag <= 1'b1;
      else if (ack_wr)
         flag <= 1'b0;
   end

   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      load_wr |=> (count == $past(load_data))); // R2
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load_wr) |=> $stable(count)); // R10
   AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !at_zero) |=> (count == $past(count) - ONE)); // R5
   AST_WRAP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && at_zero && !periodic) |=> (&count)); // R7
   AST_RELOAD_PER: assert property (@(posedge clk) disable iff (!rst_n)
      (step && at_zero && periodic) |=> (count == $past(start_val))); // R7
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      hits_zero |=> flag); // R9
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && !hits_zero) |=> !flag); // R8

endmodule

// File: rtl/dtim_apb_regs.sv
module dtim_apb_regs
   import dtim_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              flag,
   output logic [CNT_W-1:0]  start_val,
   output ctl_t              ctl,
   output logic              load_wr,
   output logic              ack_wr
);

   reg_sel_e sel;
   logic     wr_en;
   logic     ctl_wr;

   assign sel     = reg_sel_e'(paddr[3:2]);
   assign wr_en   = psel & penable & pwrite;
   assign load_wr = wr_en & (sel == SEL_START);
   assign ctl_wr  = wr_en & (sel == SEL_CTRL);
   assign ack_wr  = wr_en & (sel == SEL_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         start_val <= '0;
      else if (load_wr)
         start_val <= pwdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl <= '0;
      else if (ctl_wr) begin
         ctl.code     <= pwdata[CTL_PSC_LSB +: CODE_W];
         ctl.periodic <= pwdata[CTL_PER_BIT];
         ctl.run      <= pwdata[CTL_RUN_BIT];
      end
   end

   always_comb begin
      prdata = '0;
      case (sel)
         SEL_START: prdata[CNT_W-1:0] = start_val;
         SEL_COUNT: prdata[CNT_W-1:0] = count;
         SEL_CTRL: begin
            prdata[CTL_PSC_LSB +: CODE_W] = ctl.code;
            prdata[CTL_PER_BIT]           = ctl.periodic;
            prdata[CTL_RUN_BIT]           = ctl.run;
            prdata[CTL_STS_BIT]           = flag;
         end
         default: prdata = '0;
      endcase
   end

   AST_CTL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(ctl)); // R4
   AST_START_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !load_wr |=> $stable(start_val)); // R3
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({load_wr, ctl_wr, ack_wr}) <= 1); // R2

endmodule

// File: rtl/apb_dtimer.sv
module apb_dtimer
   import dtim_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic              irq
);

   if (ADDR_W < 4) begin : g_chk_addr
      $error("ADDR_W must cover four word registers");
   end
   if (DATA_W < CNT_W || DATA_W <= CTL_STS_BIT) begin : g_chk_data
      $error("DATA_W too narrow for count or control fields");
   end
   if (CNT_W < 2) begin : g_chk_cnt
      $error("CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] start_val;
   logic [CNT_W-1:0] count;
   ctl_t             ctl;
   logic             load_wr;
   logic             ack_wr;
   logic             tick;
   logic             flag;

   dtim_apb_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk       (pclk),
      .rst_n     (presetn),
      .psel      (psel),
      .penable   (penable),
      .pwrite    (pwrite),
      .paddr     (paddr),
      .pwdata    (pwdata),
      .prdata    (prdata),
      .count     (count),
      .flag      (flag),
      .start_val (start_val),
      .ctl       (ctl),
      .load_wr   (load_wr),
      .ack_wr    (ack_wr)
   );

   dtim_prescaler #(
      .PW (PSC_W)
   ) u_psc (
      .clk     (pclk),
      .rst_n   (presetn),
      .run     (ctl.run),
      .restart (load_wr),
      .code    (ctl.code),
      .tick    (tick)
   );

   dtim_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk       (pclk),
      .rst_n     (presetn),
      .tick      (tick),
      .periodic  (ctl.periodic),
      .load_wr   (load_wr),
      .start_val (start_val),
      .load_data (pwdata[CNT_W-1:0]),
      .ack_wr    (ack_wr),
      .count     (count),
      .flag      (flag)
   );

   assign irq     = flag;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   AST_IRQ_ROSE_ON_TICK: assert property (@(posedge pclk) disable iff (!presetn)
      $rose(irq) |-> ($past(tick) && $past(count) == {{(CNT_W-1){1'b0}}, 1'b1})); // R6

endmodule

// File: tb/apb_dtimer_bench.sv
`timescale 1ns/1ps
module apb_dtimer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [3:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr, irq;
   int          cyc = 0;
   int          n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   apb_dtimer u_apb_dtimer (
      .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(posedge clk); #1 penable = 1'b1;
      @(posedge clk); #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(posedge clk); #1 penable = 1'b1;
      #1 d = prdata;
      @(posedge clk); #1 psel = 1'b0; penable = 1'b0;
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) begin @(posedge clk); #1; end
   endtask

   task automatic wait_irq(output int t);
      t = -1;
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk); #1;
         if (irq) begin t = cyc; break; end
      end
   endtask

   function automatic int ratio(input int code);
      case (code)
         0: return 1;    1: return 16;  2: return 256; 3: return 2;
         4: return 8;    5: return 32;  6: return 128; default: return 1024;
      endcase
   endfunction

   initial begin
      #(5.0 * 190000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int t0, ti, td, t1, ph, v, tl;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      check("R1 irq", {31'd0, irq}, 32'd0);
      rd(4'h0, d); check("R1 start", d, 32'd0);
      rd(4'h4, d); check("R1 count", d, 32'd0);
      rd(4'h8, d); check("R1 ctrl", d, 32'd0);
      // R12 handshake
      check("R12 pready", {31'd0, pready}, 32'd1);
      check("R12 pslverr", {31'd0, pslverr}, 32'd0);

      // R2 start value, immediate copy
      wr(4'h0, 32'hABCD_1234);
      rd(4'h0, d); check("R2 start readback", d, 32'h0000_1234);
      rd(4'h4, d); check("R2 count copy", d, 32'h0000_1234);
      // R3 count read-only
      wr(4'h4, 32'h0000_5555);
      rd(4'h4, d); check("R3 count unchanged", d, 32'h0000_1234);
      rd(4'h0, d); check("R3 start unchanged", d, 32'h0000_1234);
      // R4 reserved bits and read-only status
      wr(4'h8, 32'hFFFF_FF3F);
      rd(4'h8, d); check("R4 code only", d, 32'h0000_001C);
      wr(4'h8, 32'h0000_0123);
      rd(4'h8, d); check("R4 reserved zero", d, 32'd0);
      // R8 clear register reads zero
      rd(4'hC, d); check("R8 ack reads 0", d, 32'd0);

      // R5/R6 sweep over every ratio code, free-running, N=3
      for (int c = 0; c < 8; c++) begin
         wr(4'h8, 32'(c << 2));
         wr(4'h0, 32'd3);
         wr(4'hC, 32'd0);
         wr(4'h8, 32'h80 | 32'(c << 2));
         t0 = cyc;
         wait_irq(ti);
         check($sformatf("R5 code %0d edges to irq", c), 32'(ti - t0), 32'(3 * ratio(c)));
         rd(4'h8, d);
         check($sformatf("R6 code %0d status bit", c), d, 32'h180 | 32'(c << 2));
         wr(4'h8, 32'd0);
      end

      // R7 free-running wrap, ratio 256
      wr(4'h8, 32'h08); wr(4'h0, 32'd2); wr(4'hC, 32'd1);
      wr(4'h8, 32'h88);
      wait_irq(ti);
      rd(4'h4, d); check("R7 free zero", d, 32'd0);
      wait_until(ti + 255);
      rd(4'h4, d); check("R7 free wrap", d, 32'h0000_FFFF);
      wr(4'h8, 32'h08);

      // R7 periodic reload and period
      wr(4'h0, 32'd2); wr(4'hC, 32'd1);
      wr(4'h8, 32'hC8);
      wait_irq(ti);
      wr(4'hC, 32'd0);
      wait_until(ti + 255);
      rd(4'h4, d); check("R7 periodic reload", d, 32'd2);
      wait_irq(t1);
      check("R7 periodic interval", 32'(t1 - ti), 32'(3 * 256));

      // R8 clear with arbitrary data
      wr(4'h8, 32'd0);
      wr(4'hC, 32'hDEAD_BEEF);
      check("R8 irq cleared", {31'd0, irq}, 32'd0);
      rd(4'h8, d); check("R8 status cleared", d, 32'd0);

      // R9 set wins over clear on the same edge (ratio 1)
      wr(4'h8, 32'h80);
      wr(4'h0, 32'd1);
      wr(4'h0, 32'd2);
      wr(4'hC, 32'd0);
      check("R9 set wins", {31'd0, irq}, 32'd1);
      wr(4'hC, 32'd0);
      wr(4'h0, 32'd3);
      wr(4'hC, 32'd0);
      check("R8 clear one edge early", {31'd0, irq}, 32'd0);
      @(posedge clk); #1;
      check("R6 set after early clear", {31'd0, irq}, 32'd1);

      // R10 freeze and resume phase, ratio 16
      wr(4'h8, 32'h04);
      wr(4'h0, 32'd100);
      wr(4'h8, 32'h84);
      t0 = cyc;
      wait_until(t0 + 41);
      wr(4'h8, 32'h04);
      td = cyc;
      v  = 100 - (td - t0) / 16;
      ph = (td - t0) % 16;
      rd(4'h4, d); check("R10 frozen value", d, 32'(v));
      repeat (50) @(posedge clk);
      #1;
      rd(4'h4, d); check("R10 still frozen", d, 32'(v));
      wr(4'h8, 32'h84);
      t1 = cyc;
      wait_until(t1 + 16 - ph - 2);
      rd(4'h4, d); check("R10 resume phase before", d, 32'(v));
      rd(4'h4, d); check("R10 resume phase after", d, 32'(v - 1));

      // R11 start write restarts the divider
      wr(4'h0, 32'd5);
      tl = cyc;
      wait_until(tl + 14);
      rd(4'h4, d); check("R11 no early tick", d, 32'd5);
      rd(4'h4, d); check("R11 tick after full ratio", d, 32'd4);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule